// File: doc/BRIEF.md
# Threshold-Driven Audio Sample FIFO Pair

This block holds two sample queues for an audio serial port: a transmit queue that the system bus fills and the serializer drains, and a receive queue that the serializer fills and the system bus drains. Each queue holds 32 samples of 32 bits, keeps a live fill count, and raises a DMA request based on how its fill count compares with a programmable threshold. The transmit request asks for more data while there is room for a burst. The receive request asks for the data to be collected once enough samples are waiting. Both sides of both queues run on one clock.

A single 32-bit control word configures the block. It holds a per-queue DMA enable, a per-queue 5-bit threshold, and a per-queue flush bit. Writing the control word with a flush bit set empties that queue in the same clock edge, without a global reset. The flush bit is not stored. Misuse is recorded in sticky status outputs and is not silently lost: a write to a full queue is dropped and sets an overflow flag, and a read from an empty queue returns zero and sets an underflow flag. A DMA engine typically moves 16-word bursts against the default threshold of 16.

Top module: `audio_fifo_pair`

## Requirements
- R1: After reset both levels are 0, both DMA requests are low and all four status flags are low.
- R2: Each queue returns samples in the order they were written. The read data is presented combinationally while the queue is not empty. The level output counts the stored samples and never exceeds 32.
- R3: A write to a full queue is dropped and leaves its level at 32. It sets that queue's overflow flag, which stays set until the queue is flushed or reset.
- R4: A read from an empty queue shows zero on the read data and leaves the level at 0. It sets that queue's underflow flag, which stays set until the queue is flushed or reset.
- R5: A control write with bit 0 set empties the transmit queue at that clock edge, and bit 1 does the same for the receive queue. The flush also clears that queue's status flags, and the other queue is not affected.
- R6: Control bit 4 enables the transmit DMA request and bit 5 enables the receive DMA request. While an enable is clear, its request stays low. An all-zero control word therefore disables both requests.
- R7: With its DMA enabled, the transmit request is high exactly when the free space (32 minus the level) is at least the transmit threshold. The transmit threshold is held in control bits 12:8.
- R8: With its DMA enabled, the receive request is high exactly when the level is at least the receive threshold. The receive threshold is held in control bits 20:16.
- R9: A threshold field of 0 stands for 32. The reset value of both threshold fields is 16.
- R10: A read and a write in the same cycle on a queue that is neither empty nor full are both accepted and leave the level unchanged. On a full queue the read is accepted and the write is dropped as an overflow.
- R11: A flush takes priority over a read or write to the same queue in the same cycle, and the level is 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both queues |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWe | input | 1 | Control word write strobe |
| ctrlWdata | input | 32 | Control word: flushes, DMA enables, thresholds |
| txWrEn | input | 1 | Bus writes a sample into the transmit queue |
| txWrData | input | 32 | Transmit sample from the bus |
| txRdEn | input | 1 | Serializer takes a sample from the transmit queue |
| txRdData | output | 32 | Head sample of the transmit queue, zero when empty |
| txLevel | output | 6 | Samples held in the transmit queue |
| txDmaReq | output | 1 | Transmit DMA request |
| txOverflow | output | 1 | Sticky: write to a full transmit queue |
| txUnderflow | output | 1 | Sticky: read from an empty transmit queue |
| rxWrEn | input | 1 | Serializer writes a sample into the receive queue |
| rxWrData | input | 32 | Receive sample from the serializer |
| rxRdEn | input | 1 | Bus takes a sample from the receive queue |
| rxRdData | output | 32 | Head sample of the receive queue, zero when empty |
| rxLevel | output | 6 | Samples held in the receive queue |
| rxDmaReq | output | 1 | Receive DMA request |
| rxOverflow | output | 1 | Sticky: write to a full receive queue |
| rxUnderflow | output | 1 | Sticky: read from an empty receive queue |

## Verification
The cycle-level properties are checked on every clock:
- the level bound;
- a full-queue write that leaves the level at 32 and sets overflow;
- zero data on an empty read;
- the stickiness of the flags;
- a flush that empties the queue and clears its flags;
- a cleared enable that forces the request low;
- a level that holds still on a simultaneous read and write.

Only the directed scenarios can show the rest:
- sample ordering and the exact data values;
- the threshold comparisons at their boundary levels;
- the encoding of 0 as 32;
- that a flush of one queue leaves the other queue's contents intact.

// File: rtl/afifo_pkg.sv
package afifo_pkg;

  localparam int CTRL_W       = 32;
  localparam int THR_W        = 5;
  localparam int THR_DEFAULT  = 16;

  localparam int TX_FLUSH_BIT = 0;
  localparam int RX_FLUSH_BIT = 1;
  localparam int TX_DMA_BIT   = 4;
  localparam int RX_DMA_BIT   = 5;
  localparam int TX_THR_LSB   = 8;
  localparam int RX_THR_LSB   = 16;

  localparam int CH_TX = 0;
  localparam int CH_RX = 1;
  localparam int NUM_CH = 2;

  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } fifo_strobe_t;

  typedef struct packed {
    logic             dmaEn;
    logic [THR_W-1:0] thr;
  } chan_cfg_t;

endpackage

// File: rtl/afifo_cfg.sv
module afifo_cfg
  import afifo_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     ctrlWe,
  input  logic [CTRL_W-1:0]        ctrlWdata,
  output chan_cfg_t [NUM_CH-1:0]   chanCfg,
  output logic [NUM_CH-1:0]        flushReq
);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam int FLUSH_POS = (ch == CH_TX) ? TX_FLUSH_BIT : RX_FLUSH_BIT;
    localparam int DMA_POS   = (ch == CH_TX) ? TX_DMA_BIT   : RX_DMA_BIT;
    localparam int THR_POS   = (ch == CH_TX) ? TX_THR_LSB   : RX_THR_LSB;

    // flush bit is a pulse: acts at this edge, never stored
    assign flushReq[ch] = ctrlWe & ctrlWdata[FLUSH_POS];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        chanCfg[ch].dmaEn <= 1'b0;
        chanCfg[ch].thr   <= THR_W'(THR_DEFAULT);
      end else if (ctrlWe) begin
        chanCfg[ch].dmaEn <= ctrlWdata[DMA_POS];
        chanCfg[ch].thr   <= ctrlWdata[THR_POS +: THR_W];
      end
    end
  end

  logic unusedCtrlBits;
  assign unusedCtrlBits = ^{ctrlWdata[31:21], ctrlWdata[15:13],
                            ctrlWdata[7:6], ctrlWdata[3:2]};

endmodule

// File: rtl/afifo_ctrl.sv
module afifo_ctrl
  import afifo_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter bit IS_TX = 1'b1,
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrReq,
  input  logic             rdReq,
  input  logic             flushReq,
  input  chan_cfg_t        cfg,
  output fifo_strobe_t     strobe,
  output logic             hasData,
  output logic [LVL_W-1:0] level,
  output logic             overflow,
  output logic             underflow,
  output logic             dmaReq
);

  logic             isFull;
  logic             isEmpty;
  logic [LVL_W-1:0] thrEff;
  logic [LVL_W-1:0] freeSlots;
  logic             thrMet;

  assign isFull  = (level == LVL_W'(DEPTH));
  assign isEmpty = (level == '0);
  assign hasData = !isEmpty;

  // flush wins over traffic; full blocks push, empty blocks pop
  always_comb begin
    strobe.flush = flushReq;
    strobe.push  = wrReq & !isFull  & !flushReq;
    strobe.pop   = rdReq & !isEmpty & !flushReq;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.flush) begin
      level <= '0;
    end else begin
      case ({strobe.push, strobe.pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.flush) begin
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      if (wrReq && isFull)  overflow  <= 1'b1;
      if (rdReq && isEmpty) underflow <= 1'b1;
    end
  end

  // a zero field encodes the full depth
  assign thrEff    = (cfg.thr == '0) ? LVL_W'(DEPTH) : LVL_W'(cfg.thr);
  assign freeSlots = LVL_W'(DEPTH) - level;

  if (IS_TX) begin : g_txReq
    assign thrMet = (freeSlots >= thrEff);
  end else begin : g_rxReq
    assign thrMet = (level >= thrEff);
  end

  assign dmaReq = cfg.dmaEn & thrMet;

endmodule

// File: rtl/afifo_data.sv
module afifo_data
  import afifo_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifo_strobe_t     strobe,
  input  logic             hasData,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData
);

  logic [WIDTH-1:0] store [DEPTH];
  logic [AW-1:0]    wrPtr;
  logic [AW-1:0]    rdPtr;

  always_ff @(posedge clk) begin
    if (!rstN || strobe.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.push) wrPtr <= wrPtr + 1'b1;
      if (strobe.pop)  rdPtr <= rdPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.push) store[wrPtr] <= wrData;
  end

  assign rdData = hasData ? store[rdPtr] : '0;

endmodule

// File: rtl/audio_fifo_pair.sv
module audio_fifo_pair
  import afifo_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int WIDTH = 32,
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWe,
  input  logic [CTRL_W-1:0] ctrlWdata,
  input  logic              txWrEn,
  input  logic [WIDTH-1:0]  txWrData,
  input  logic              txRdEn,
  output logic [WIDTH-1:0]  txRdData,
  output logic [LVL_W-1:0]  txLevel,
  output logic              txDmaReq,
  output logic              txOverflow,
  output logic              txUnderflow,
  input  logic              rxWrEn,
  input  logic [WIDTH-1:0]  rxWrData,
  input  logic              rxRdEn,
  output logic [WIDTH-1:0]  rxRdData,
  output logic [LVL_W-1:0]  rxLevel,
  output logic              rxDmaReq,
  output logic              rxOverflow,
  output logic              rxUnderflow
);

  chan_cfg_t [NUM_CH-1:0]              chanCfg;
  logic      [NUM_CH-1:0]              flushReq;
  logic      [NUM_CH-1:0]              wrReq;
  logic      [NUM_CH-1:0]              rdReq;
  logic      [NUM_CH-1:0][WIDTH-1:0]   wrDataA;
  logic      [NUM_CH-1:0][WIDTH-1:0]   rdDataA;
  logic      [NUM_CH-1:0][LVL_W-1:0]   levelA;
  logic      [NUM_CH-1:0]              dmaReqA;
  logic      [NUM_CH-1:0]              ovfA;
  logic      [NUM_CH-1:0]              udfA;

  assign wrReq[CH_TX]   = txWrEn;
  assign wrReq[CH_RX]   = rxWrEn;
  assign rdReq[CH_TX]   = txRdEn;
  assign rdReq[CH_RX]   = rxRdEn;
  assign wrDataA[CH_TX] = txWrData;
  assign wrDataA[CH_RX] = rxWrData;

  afifo_cfg u_cfg (
    .clk       (clk),
    .rstN      (rstN),
    .ctrlWe    (ctrlWe),
    .ctrlWdata (ctrlWdata),
    .chanCfg   (chanCfg),
    .flushReq  (flushReq)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    fifo_strobe_t strobe;
    logic         hasData;

    afifo_ctrl #(
      .DEPTH (DEPTH),
      .IS_TX (ch == CH_TX)
    ) u_ctrl (
      .clk       (clk),
      .rstN      (rstN),
      .wrReq     (wrReq[ch]),
      .rdReq     (rdReq[ch]),
      .flushReq  (flushReq[ch]),
      .cfg       (chanCfg[ch]),
      .strobe    (strobe),
      .hasData   (hasData),
      .level     (levelA[ch]),
      .overflow  (ovfA[ch]),
      .underflow (udfA[ch]),
      .dmaReq    (dmaReqA[ch])
    );

    afifo_data #(
      .DEPTH (DEPTH),
      .WIDTH (WIDTH)
    ) u_data (
      .clk     (clk),
      .rstN    (rstN),
      .strobe  (strobe),
      .hasData (hasData),
      .wrData  (wrDataA[ch]),
      .rdData  (rdDataA[ch])
    );
  end

  assign txRdData    = rdDataA[CH_TX];
  assign rxRdData    = rdDataA[CH_RX];
  assign txLevel     = levelA[CH_TX];
  assign rxLevel     = levelA[CH_RX];
  assign txDmaReq    = dmaReqA[CH_TX];
  assign rxDmaReq    = dmaReqA[CH_RX];
  assign txOverflow  = ovfA[CH_TX];
  assign rxOverflow  = ovfA[CH_RX];
  assign txUnderflow = udfA[CH_TX];
  assign rxUnderflow = udfA[CH_RX];

endmodule

// File: rtl/afifo_chk.sv
module afifo_chk
  import afifo_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int WIDTH = 32,
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              ctrlWe,
  input logic [CTRL_W-1:0] ctrlWdata,
  input logic              txWrEn,
  input logic              txRdEn,
  input logic [WIDTH-1:0]  txRdData,
  input logic [LVL_W-1:0]  txLevel,
  input logic              txDmaReq,
  input logic              txOverflow,
  input logic              txUnderflow,
  input logic              rxWrEn,
  input logic              rxRdEn,
  input logic [WIDTH-1:0]  rxRdData,
  input logic [LVL_W-1:0]  rxLevel,
  input logic              rxDmaReq,
  input logic              rxOverflow,
  input logic              rxUnderflow
);

  logic txFl;
  logic rxFl;
  assign txFl = ctrlWe && ctrlWdata[TX_FLUSH_BIT];
  assign rxFl = ctrlWe && ctrlWdata[RX_FLUSH_BIT];

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (txLevel <= LVL_W'(DEPTH)) && (rxLevel <= LVL_W'(DEPTH))); // R2

  AST_TX_FULL_DROP: assert property (@(posedge clk) disable iff (!rstN)
    !txFl && txLevel == LVL_W'(DEPTH) && txWrEn && !txRdEn
    |=> txLevel == LVL_W'(DEPTH) && txOverflow); // R3

  AST_RX_FULL_DROP: assert property (@(posedge clk) disable iff (!rstN)
    !rxFl && rxLevel == LVL_W'(DEPTH) && rxWrEn && !rxRdEn
    |=> rxLevel == LVL_W'(DEPTH) && rxOverflow); // R3

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    txOverflow && !txFl |=> txOverflow); // R3

  AST_UDF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    rxUnderflow && !rxFl |=> rxUnderflow); // R4

  AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (txLevel == '0 && txRdEn |-> txRdData == '0) and
    (rxLevel == '0 && rxRdEn |-> rxRdData == '0)); // R4

  AST_TX_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    txFl |=> txLevel == '0 && !txOverflow && !txUnderflow); // R5

  AST_RX_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    rxFl |=> rxLevel == '0 && !rxOverflow && !rxUnderflow); // R5

  AST_TX_DMA_OFF: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWe && !ctrlWdata[TX_DMA_BIT] |=> !txDmaReq); // R6

  AST_RX_DMA_OFF: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWe && !ctrlWdata[RX_DMA_BIT] |=> !rxDmaReq); // R6

  AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !txFl && txLevel != '0 && txLevel != LVL_W'(DEPTH) && txWrEn && txRdEn
    |=> $stable(txLevel)); // R10

endmodule

bind audio_fifo_pair afifo_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_afifo_chk (
  .clk         (clk),
  .rstN        (rstN),
  .ctrlWe      (ctrlWe),
  .ctrlWdata   (ctrlWdata),
  .txWrEn      (txWrEn),
  .txRdEn      (txRdEn),
  .txRdData    (txRdData),
  .txLevel     (txLevel),
  .txDmaReq    (txDmaReq),
  .txOverflow  (txOverflow),
  .txUnderflow (txUnderflow),
  .rxWrEn      (rxWrEn),
  .rxRdEn      (rxRdEn),
  .rxRdData    (rxRdData),
  .rxLevel     (rxLevel),
  .rxDmaReq    (rxDmaReq),
  .rxOverflow  (rxOverflow),
  .rxUnderflow (rxUnderflow)
);

// File: tb/test_audio_fifo_pair.sv
module test_audio_fifo_pair;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctrlWe = 1'b0;
  logic [31:0] ctrlWdata = '0;
  logic        txWrEn = 1'b0;
  logic [31:0] txWrData = '0;
  logic        txRdEn = 1'b0;
  logic [31:0] txRdData;
  logic [5:0]  txLevel;
  logic        txDmaReq, txOverflow, txUnderflow;
  logic        rxWrEn = 1'b0;
  logic [31:0] rxWrData = '0;
  logic        rxRdEn = 1'b0;
  logic [31:0] rxRdData;
  logic [5:0]  rxLevel;
  logic        rxDmaReq, rxOverflow, rxUnderflow;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  audio_fifo_pair i_audio_fifo_pair (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .txWrEn(txWrEn), .txWrData(txWrData), .txRdEn(txRdEn), .txRdData(txRdData),
    .txLevel(txLevel), .txDmaReq(txDmaReq), .txOverflow(txOverflow),
    .txUnderflow(txUnderflow),
    .rxWrEn(rxWrEn), .rxWrData(rxWrData), .rxRdEn(rxRdEn), .rxRdData(rxRdData),
    .rxLevel(rxLevel), .rxDmaReq(rxDmaReq), .rxOverflow(rxOverflow),
    .rxUnderflow(rxUnderflow)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkCtrl(input bit txFl, input bit rxFl,
                                          input bit txEn, input bit rxEn,
                                          input logic [4:0] txThr, input logic [4:0] rxThr);
    logic [31:0] w = '0;
    w[0] = txFl; w[1] = rxFl; w[4] = txEn; w[5] = rxEn;
    w[12:8] = txThr; w[20:16] = rxThr;
    return w;
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic writeCtrl(input logic [31:0] w);
    ctrlWe = 1'b1; ctrlWdata = w;
    step();
    ctrlWe = 1'b0; ctrlWdata = '0;
  endtask

  task automatic pushTx(input int n, input logic [31:0] base);
    for (int i = 0; i < n; i++) begin
      txWrEn = 1'b1; txWrData = base + i;
      step();
    end
    txWrEn = 1'b0;
  endtask

  task automatic pushRx(input int n, input logic [31:0] base);
    for (int i = 0; i < n; i++) begin
      rxWrEn = 1'b1; rxWrData = base + i;
      step();
    end
    rxWrEn = 1'b0;
  endtask

  task automatic tReset();
    check("R1 txLevel", 32'(txLevel), 0);
    check("R1 rxLevel", 32'(rxLevel), 0);
    check("R1 dma reqs", {30'd0, txDmaReq, rxDmaReq}, 0);
    check("R1 flags", {28'd0, txOverflow, txUnderflow, rxOverflow, rxUnderflow}, 0);
  endtask

  task automatic tOrder();
    writeCtrl(mkCtrl(1, 1, 0, 0, 16, 16));
    pushTx(5, 32'hA000);
    check("R2 txLevel after 5", 32'(txLevel), 5);
    for (int i = 0; i < 5; i++) begin
      txRdEn = 1'b1;
      #1 check("R2 tx order", txRdData, 32'hA000 + i);
      step();
    end
    txRdEn = 1'b0;
    check("R2 txLevel drained", 32'(txLevel), 0);
    pushRx(3, 32'h5000);
    for (int i = 0; i < 3; i++) begin
      rxRdEn = 1'b1;
      #1 check("R2 rx order", rxRdData, 32'h5000 + i);
      step();
    end
    rxRdEn = 1'b0;
    check("R2 rxLevel drained", 32'(rxLevel), 0);
  endtask

  task automatic tFull();
    writeCtrl(mkCtrl(1, 0, 0, 0, 16, 16));
    pushTx(32, 32'h100);
    check("R3 level full", 32'(txLevel), 32);
    check("R3 no overflow yet", 32'(txOverflow), 0);
    pushTx(1, 32'hDEAD);
    check("R3 level stays 32", 32'(txLevel), 32);
    check("R3 overflow set", 32'(txOverflow), 1);
    txWrEn = 1'b1; txWrData = 32'hBEEF; txRdEn = 1'b1;
    #1 check("R10 head at full", txRdData, 32'h100);
    step();
    check("R10 full: pop only", 32'(txLevel), 31);
    #1 check("R10 head advanced", txRdData, 32'h101);
    step();
    txWrEn = 1'b0; txRdEn = 1'b0;
    check("R10 mid: level held", 32'(txLevel), 31);
    check("R3 overflow sticky", 32'(txOverflow), 1);
    for (int i = 0; i < 30; i++) begin
      txRdEn = 1'b1;
      step();
    end
    #1 check("R3 dropped word absent", txRdData, 32'hBEEF);
    step();
    txRdEn = 1'b0;
  endtask

  task automatic tEmpty();
    writeCtrl(mkCtrl(1, 1, 0, 0, 16, 16));
    check("R5 flush clears overflow", 32'(txOverflow), 0);
    txRdEn = 1'b1;
    #1 check("R4 tx empty read zero", txRdData, 0);
    step();
    txRdEn = 1'b0;
    check("R4 tx underflow", 32'(txUnderflow), 1);
    check("R4 tx level 0", 32'(txLevel), 0);
    rxRdEn = 1'b1;
    #1 check("R4 rx empty read zero", rxRdData, 0);
    step();
    rxRdEn = 1'b0;
    check("R4 rx underflow", 32'(rxUnderflow), 1);
    step();
    check("R4 underflow sticky", 32'(rxUnderflow), 1);
  endtask

  task automatic tFlush();
    writeCtrl(mkCtrl(1, 0, 0, 0, 16, 16));
    pushTx(3, 32'h300);
    pushRx(4, 32'h400);
    writeCtrl(mkCtrl(1, 0, 0, 0, 16, 16));
    check("R5 tx flushed", 32'(txLevel), 0);
    check("R5 rx untouched", 32'(rxLevel), 4);
    check("R5 rx flag untouched", 32'(rxUnderflow), 1);
    #1 check("R5 rx head intact", rxRdData, 32'h400);
    rxWrEn = 1'b1; rxWrData = 32'h999;
    writeCtrl(mkCtrl(0, 1, 0, 0, 16, 16));
    rxWrEn = 1'b0;
    check("R11 flush beats write", 32'(rxLevel), 0);
    check("R5 rx flag cleared", 32'(rxUnderflow), 0);
  endtask

  task automatic tDma();
    writeCtrl(mkCtrl(1, 1, 1, 0, 16, 16));
    check("R7 empty tx req", 32'(txDmaReq), 1);
    check("R6 rx disabled", 32'(rxDmaReq), 0);
    pushTx(16, 0);
    check("R7 free 16 req", 32'(txDmaReq), 1);
    pushTx(1, 0);
    check("R7 free 15 no req", 32'(txDmaReq), 0);
    writeCtrl(mkCtrl(1, 0, 1, 0, 1, 16));
    check("R7 thr 1 at level 0", 32'(txDmaReq), 1);
    writeCtrl(mkCtrl(0, 0, 0, 1, 16, 4));
    check("R6 tx disabled", 32'(txDmaReq), 0);
    pushRx(3, 0);
    check("R8 level 3 below 4", 32'(rxDmaReq), 0);
    pushRx(1, 0);
    check("R8 level 4 meets 4", 32'(rxDmaReq), 1);
    writeCtrl(mkCtrl(0, 0, 0, 1, 16, 0));
    check("R9 rx thr 0 at level 4", 32'(rxDmaReq), 0);
    pushRx(28, 0);
    check("R9 rx thr 0 at level 32", 32'(rxDmaReq), 1);
    writeCtrl(mkCtrl(1, 0, 1, 1, 0, 0));
    check("R9 tx thr 0 at free 32", 32'(txDmaReq), 1);
    pushTx(1, 0);
    check("R9 tx thr 0 at free 31", 32'(txDmaReq), 0);
    writeCtrl('0);
    check("R6 zero word tx off", 32'(txDmaReq), 0);
    check("R6 zero word rx off", 32'(rxDmaReq), 0);
    check("R6 zero word keeps rx data", 32'(rxLevel), 32);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    step(); step();
    tReset();
    rstN = 1'b1;
    step();
    tReset();
    tOrder();
    tFull();
    tEmpty();
    tFlush();
    tDma();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule